// File: doc/BRIEF.md
# Merging Write Buffer for a Memory Controller

This block is a short queue that sits between a memory front end and the DRAM command scheduler. It holds write data that is waiting for the DRAM. Each entry covers a contiguous byte range inside one burst-aligned window. When a new write arrives, it is compared against every live entry. The write is folded into an entry when its byte range shares bytes with that entry. It is also folded in when the write touches the entry's range end to end, on either side, inside the same burst window. Otherwise the write opens a fresh entry. Folding writes in this way saves the scheduler from issuing several bursts to the same place.

Entries leave toward the scheduler strictly in the order they were opened. A read lookup searches the buffer. If the freshest copy of every requested byte is in one entry, the read is answered from the buffer after a fixed front-end delay and never reaches the DRAM.

Requests larger than one burst are split into burst-sized pieces upstream, so every write and read presented here fits in one burst window. A byte address is split into a window tag and a byte offset (offset = low log2(BURST_BYTES) bits). Data buses are lane aligned: byte lane b carries the byte at offset b. DEPTH must be a power of two and at least 2.

Top module: `wmb_top`

## Requirements
- R1: After reset the buffer is empty: `dr_valid_o` is 0, `wr_ready_o` is 1 and `rd_rsp_valid_o` is 0.
- R2: A write whose range [off, off+len-1] shares at least one byte with a live entry of the same window is merged into that entry, and the entry's range grows to the union.
- R3: A write that ends on the byte just before an entry's first byte, or starts on the byte just after an entry's last byte, in the same window, is merged into that entry.
- R4: A write that leaves a gap to every live entry of its window, or that belongs to another window (including one touching end to end across a window boundary), opens a new entry.
- R5: In a merge, only bytes that lie in the write's range and have their byte enable set take the new value and become valid in the entry. Other bytes keep their old data and valid state. If several entries qualify, the most recently opened one is chosen.
- R6: The drain port presents the oldest entry: `dr_tag_o` is the window tag, `dr_strb_o` holds the per-byte valid bits (bit b = offset b) and `dr_data_o` holds the lane data. The entry is held until `dr_ready_i` is 1, and entries leave in the order they were opened.
- R7: When all DEPTH entries are live, `wr_ready_o` is 1 only if the presented write can merge. A write presented while `wr_ready_o` is 0 leaves no trace in the buffer.
- R8: A read is looked up in the most recently opened live entry whose range shares a byte with the read. If that entry's valid bits cover every requested byte, then exactly FE_LAT cycles after the read is presented `rd_rsp_valid_o` = 1, `rd_rsp_hit_o` = 1 and `rd_rsp_data_o` carries that entry's lane data.
- R9: Otherwise, a read gives `rd_rsp_valid_o` = 1 with `rd_rsp_hit_o` = 0 and `rd_rsp_data_o` = 0, with the same FE_LAT delay. This covers a read with no overlapping entry, and a read where the chosen entry lacks a requested byte.
- R10: The entry being drained in a cycle (`dr_valid_o` and `dr_ready_i` both 1) is never a merge target in that cycle. A write that would have merged with it opens a new entry instead.
- R11: A write must satisfy len ≥ 1 and off + len ≤ BURST_BYTES. A write that ends on the last byte of its window is accepted like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write request present |
| wr_ready_o | output | 1 | Write can be taken this cycle |
| wr_addr_i | input | ADDR_W | Byte address of the first written byte |
| wr_len_i | input | log2(BURST_BYTES)+1 | Number of bytes in the write range |
| wr_data_i | input | 8*BURST_BYTES | Lane-aligned write data |
| wr_be_i | input | BURST_BYTES | Per-lane byte enables |
| rd_valid_i | input | 1 | Read lookup present |
| rd_addr_i | input | ADDR_W | Byte address of the first read byte |
| rd_len_i | input | log2(BURST_BYTES)+1 | Number of bytes read |
| rd_rsp_valid_o | output | 1 | Lookup result valid, FE_LAT cycles after the read |
| rd_rsp_hit_o | output | 1 | Read fully served from the buffer |
| rd_rsp_data_o | output | 8*BURST_BYTES | Lane-aligned read data, zero on a miss |
| dr_valid_o | output | 1 | Oldest entry presented to the scheduler |
| dr_ready_i | input | 1 | Scheduler takes the presented entry |
| dr_tag_o | output | ADDR_W-log2(BURST_BYTES) | Window tag of the presented entry |
| dr_data_o | output | 8*BURST_BYTES | Lane data of the presented entry |
| dr_strb_o | output | BURST_BYTES | Valid bytes of the presented entry |

## Verification
The merge rule is tried with four kinds of write: one overlapping a live entry, one touching it from the right, one touching it from the left, and one leaving a gap. A write touching end to end across a window boundary is also tried; it tells true adjacency apart from a plain address comparison. A second write is sent with one enable cleared inside its range, which separates the write's range from the bytes it actually updates. Lookups are chosen to hit, to miss for lack of any entry, and to miss because the newest overlapping entry lacks one byte; together they separate full coverage from mere overlap. Further cases cover a full buffer, where a write that can merge is let through while one that cannot is held back, and a write aimed at the entry leaving the same cycle, which must open a fresh entry rather than vanish.

// File: rtl/wmb_pkg.sv
`timescale 1ns/1ps
package wmb_pkg;
  localparam int unsigned LANE_W = 8;

  function automatic logic in_span(int b, int lo, int hi);
    return (b >= lo) && (b <= hi);
  endfunction
endpackage

// File: rtl/wmb_match.sv
`timescale 1ns/1ps
module wmb_match import wmb_pkg::*; #(
  parameter int TAG_W = 13,
  parameter int OFF_W = 3,
  parameter int BB    = 8
) (
  input  logic             e_valid_i,
  input  logic [TAG_W-1:0] e_tag_i,
  input  logic [OFF_W-1:0] e_lo_i,
  input  logic [OFF_W-1:0] e_hi_i,
  input  logic [BB-1:0]    e_mask_i,
  input  logic [TAG_W-1:0] w_tag_i,
  input  logic [OFF_W-1:0] w_lo_i,
  input  logic [OFF_W-1:0] w_hi_i,
  input  logic [TAG_W-1:0] r_tag_i,
  input  logic [OFF_W-1:0] r_lo_i,
  input  logic [OFF_W-1:0] r_hi_i,
  output logic             w_near_o,
  output logic             r_isect_o,
  output logic             r_cover_o
);
  logic [BB-1:0] r_span;

  always_comb begin
    for (int b = 0; b < BB; b++) r_span[b] = in_span(b, int'(r_lo_i), int'(r_hi_i));
  end

  // near = overlap or end-to-end contact inside the same window
  assign w_near_o  = e_valid_i && (e_tag_i == w_tag_i) &&
                     (int'(w_lo_i) <= int'(e_hi_i) + 1) &&
                     (int'(w_hi_i) + 1 >= int'(e_lo_i));
  assign r_isect_o = e_valid_i && (e_tag_i == r_tag_i) &&
                     (r_lo_i <= e_hi_i) && (r_hi_i >= e_lo_i);
  assign r_cover_o = ((e_mask_i & r_span) == r_span);
endmodule

// File: rtl/wmb_fe_pipe.sv
`timescale 1ns/1ps
module wmb_fe_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/wmb_top.sv
`timescale 1ns/1ps
module wmb_top import wmb_pkg::*; #(
  parameter int ADDR_W      = 16,
  parameter int BURST_BYTES = 8,
  parameter int DEPTH       = 4,
  parameter int FE_LAT      = 2,
  localparam int OFF_W = $clog2(BURST_BYTES),
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int LEN_W = OFF_W + 1,
  localparam int DW    = LANE_W * BURST_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [BURST_BYTES-1:0] wr_be_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [LEN_W-1:0]  rd_len_i,
  output logic              rd_rsp_valid_o,
  output logic              rd_rsp_hit_o,
  output logic [DW-1:0]     rd_rsp_data_o,
  output logic              dr_valid_o,
  input  logic              dr_ready_i,
  output logic [TAG_W-1:0]  dr_tag_o,
  output logic [DW-1:0]     dr_data_o,
  output logic [BURST_BYTES-1:0] dr_strb_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [TAG_W-1:0]       tag_q  [DEPTH];
  logic [OFF_W-1:0]       lo_q   [DEPTH];
  logic [OFF_W-1:0]       hi_q   [DEPTH];
  logic [BURST_BYTES-1:0] mask_q [DEPTH];
  logic [DW-1:0]          data_q [DEPTH];
  logic [DEPTH-1:0]       valid_q;
  logic [PTR_W-1:0]       head_q, tail_q;
  logic [CNT_W-1:0]       count_q;

  logic [TAG_W-1:0] w_tag, r_tag;
  logic [OFF_W-1:0] w_lo, w_hi, r_lo, r_hi;
  logic [LEN_W-1:0] w_end, r_end;
  logic [BURST_BYTES-1:0] w_bytes;
  logic [DEPTH-1:0] w_near, r_isect, r_cover, w_cand;
  logic             pop, full, w_merge, wr_fire, alloc;
  logic [PTR_W-1:0] w_sel, r_sel;
  logic             r_any, r_hit;
  logic [DW-1:0]    r_data;

  assign w_tag = wr_addr_i[ADDR_W-1:OFF_W];
  assign w_lo  = wr_addr_i[OFF_W-1:0];
  assign w_end = {1'b0, w_lo} + wr_len_i - LEN_W'(1);
  assign w_hi  = w_end[OFF_W-1:0];
  assign r_tag = rd_addr_i[ADDR_W-1:OFF_W];
  assign r_lo  = rd_addr_i[OFF_W-1:0];
  assign r_end = {1'b0, r_lo} + rd_len_i - LEN_W'(1);
  assign r_hi  = r_end[OFF_W-1:0];

  always_comb begin
    for (int b = 0; b < BURST_BYTES; b++)
      w_bytes[b] = wr_be_i[b] && in_span(b, int'(w_lo), int'(w_hi));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    wmb_match #(.TAG_W(TAG_W), .OFF_W(OFF_W), .BB(BURST_BYTES)) u_match (
      .e_valid_i (valid_q[i]),
      .e_tag_i   (tag_q[i]),
      .e_lo_i    (lo_q[i]),
      .e_hi_i    (hi_q[i]),
      .e_mask_i  (mask_q[i]),
      .w_tag_i   (w_tag),
      .w_lo_i    (w_lo),
      .w_hi_i    (w_hi),
      .r_tag_i   (r_tag),
      .r_lo_i    (r_lo),
      .r_hi_i    (r_hi),
      .w_near_o  (w_near[i]),
      .r_isect_o (r_isect[i]),
      .r_cover_o (r_cover[i])
    );
    // the leaving entry must not absorb a write in the same cycle
    assign w_cand[i] = w_near[i] && !(pop && (PTR_W'(i) == head_q));
  end

  assign dr_valid_o = valid_q[head_q];
  assign dr_tag_o   = tag_q[head_q];
  assign dr_data_o  = data_q[head_q];
  assign dr_strb_o  = mask_q[head_q];
  assign pop        = dr_valid_o && dr_ready_i;
  assign full       = (count_q == CNT_W'(DEPTH));

  // walk oldest to newest so the newest qualifying entry wins
  always_comb begin
    w_merge = 1'b0; w_sel = head_q;
    r_any   = 1'b0; r_sel = head_q;
    for (int k = 0; k < DEPTH; k++) begin
      if (w_cand[head_q + PTR_W'(k)])  begin w_merge = 1'b1; w_sel = head_q + PTR_W'(k); end
      if (r_isect[head_q + PTR_W'(k)]) begin r_any   = 1'b1; r_sel = head_q + PTR_W'(k); end
    end
  end

  assign wr_ready_o = w_merge || !full;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign alloc      = wr_fire && !w_merge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0; lo_q[i] <= '0; hi_q[i] <= '0; mask_q[i] <= '0; data_q[i] <= '0;
      end
    end else begin
      if (pop) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= head_q + PTR_W'(1);
      end
      if (wr_fire && w_merge) begin
        lo_q[w_sel]   <= (w_lo < lo_q[w_sel]) ? w_lo : lo_q[w_sel];
        hi_q[w_sel]   <= (w_hi > hi_q[w_sel]) ? w_hi : hi_q[w_sel];
        mask_q[w_sel] <= mask_q[w_sel] | w_bytes;
        for (int b = 0; b < BURST_BYTES; b++)
          if (w_bytes[b]) data_q[w_sel][LANE_W*b +: LANE_W] <= wr_data_i[LANE_W*b +: LANE_W];
      end
      if (alloc) begin
        valid_q[tail_q] <= 1'b1;
        tag_q[tail_q]   <= w_tag;
        lo_q[tail_q]    <= w_lo;
        hi_q[tail_q]    <= w_hi;
        mask_q[tail_q]  <= w_bytes;
        for (int b = 0; b < BURST_BYTES; b++)
          data_q[tail_q][LANE_W*b +: LANE_W] <= w_bytes[b] ? wr_data_i[LANE_W*b +: LANE_W] : '0;
        tail_q <= tail_q + PTR_W'(1);
      end
      count_q <= count_q + CNT_W'(alloc) - CNT_W'(pop);
    end
  end

  assign r_hit  = rd_valid_i && r_any && r_cover[r_sel];
  assign r_data = r_hit ? data_q[r_sel] : '0;

  wmb_fe_pipe #(.W(DW + 2), .STAGES(FE_LAT)) u_fe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rd_valid_i, r_hit, r_data}),
    .q_o    ({rd_rsp_valid_o, rd_rsp_hit_o, rd_rsp_data_o})
  );

  p_empty_no_drain_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) |-> !dr_valid_o);
  p_drain_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_valid_o && !dr_ready_i) |=> (dr_valid_o && $stable(dr_tag_o)));
  p_strb_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_valid_o && !dr_ready_i) |=> (($past(dr_strb_o) & ~dr_strb_o) == '0));
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_wr_in_window_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |-> (wr_len_i != '0) && (int'(w_lo) + int'(wr_len_i) <= BURST_BYTES));
  p_hit_has_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rsp_hit_o |-> rd_rsp_valid_o);
endmodule

// File: tb/sim_wmb_top.sv
`timescale 1ns/1ps
module sim_wmb_top;
  typedef struct packed {
    logic [15:0] a;
    logic [3:0]  l;
    logic        h;
    logic [63:0] d;
  } rvec_t;

  // lookups against the state built by the directed writes
  localparam rvec_t RV [8] = '{
    '{16'h0100, 4'd4, 1'b1, 64'h0000_0000_BBAA_2211},
    '{16'h0103, 4'd2, 1'b0, 64'h0},
    '{16'h0106, 4'd2, 1'b1, 64'h7766_0000_0000_0000},
    '{16'h0108, 4'd1, 1'b1, 64'h0000_0000_0000_0099},
    '{16'h010B, 4'd3, 1'b1, 64'h0000_E5E4_B300_0000},
    '{16'h010A, 4'd2, 1'b0, 64'h0},
    '{16'h0200, 4'd8, 1'b0, 64'h0},
    '{16'h0100, 4'd8, 1'b0, 64'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0, dr_ready = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [3:0]  wr_len = '0, rd_len = '0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_be = '0;
  logic        wr_ready, rsp_valid, rsp_hit, dr_valid;
  logic [63:0] rsp_data, dr_data;
  logic [12:0] dr_tag;
  logic [7:0]  dr_strb;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wmb_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr),
    .wr_len_i(wr_len), .wr_data_i(wr_data), .wr_be_i(wr_be),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_len_i(rd_len),
    .rd_rsp_valid_o(rsp_valid), .rd_rsp_hit_o(rsp_hit), .rd_rsp_data_o(rsp_data),
    .dr_valid_o(dr_valid), .dr_ready_i(dr_ready), .dr_tag_o(dr_tag),
    .dr_data_o(dr_data), .dr_strb_o(dr_strb)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lanes(input logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = {8{m[b]}};
    return r;
  endfunction

  function automatic logic [7:0] span(input logic [15:0] a, input logic [3:0] l);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = (b >= int'(a[2:0])) && (b < int'(a[2:0]) + int'(l));
    return r;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [3:0] l, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_len = l; wr_be = be; wr_data = d;
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  task automatic rd(input rvec_t v, input string tag);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = v.a; rd_len = v.l;
    @(posedge clk); #1 rd_valid = 1'b0;
    @(posedge clk); #1;
    chk({tag, " rsp valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit"}, 64'(rsp_hit), 64'(v.h));
    chk({tag, " data"}, v.h ? (rsp_data & lanes(span(v.a, v.l))) : rsp_data, v.d);
  endtask

  task automatic drain(input logic [12:0] t, input logic [7:0] s, input logic [63:0] d, input string tag);
    @(negedge clk);
    chk({tag, " drain valid"}, 64'(dr_valid), 64'd1);
    chk({tag, " drain tag"}, 64'(dr_tag), 64'(t));
    chk({tag, " drain strb"}, 64'(dr_strb), 64'(s));
    chk({tag, " drain data"}, dr_data & lanes(s), d);
    dr_ready = 1'b1;
    @(posedge clk); #1 dr_ready = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 drain valid at reset", 64'(dr_valid), 64'd0);
    chk("R1 write ready at reset", 64'(wr_ready), 64'd1);
    chk("R1 rsp valid at reset", 64'(rsp_valid), 64'd0);
    @(negedge clk) rst_n = 1'b1;

    wr(16'h0100, 4'd4, 8'h0F, 64'h0000_0000_4433_2211);
    wr(16'h0102, 4'd4, 8'h2C, 64'h0000_DDCC_BBAA_0000);  // R2 overlap, R5 lane 4 disabled
    wr(16'h0106, 4'd2, 8'hC0, 64'h7766_0000_0000_0000);  // R3 starts after entry end
    wr(16'h0108, 4'd1, 8'h01, 64'h0000_0000_0000_0099);  // R4 next window
    wr(16'h010C, 4'd2, 8'h30, 64'h0000_E5E4_0000_0000);  // R4 gap
    wr(16'h010B, 4'd1, 8'h08, 64'h0000_0000_B300_0000);  // R3 ends before entry start

    foreach (RV[i]) rd(RV[i], RV[i].h ? "R8 lookup" : "R9 lookup");

    wr(16'h0300, 4'd8, 8'hFF, 64'h0807_0605_0403_0201);  // R11 ends on last byte; fills buffer
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 16'h0400; wr_len = 4'd1; wr_be = 8'h01; wr_data = 64'hFF;
    #1 chk("R7 full, no merge, ready", 64'(wr_ready), 64'd0);
    @(negedge clk);
    wr_addr = 16'h0307; wr_be = 8'h80; wr_data = 64'h5A00_0000_0000_0000;
    #1 chk("R7 full, mergeable, ready", 64'(wr_ready), 64'd1);
    @(posedge clk); #1 wr_valid = 1'b0;

    drain(13'h020, 8'hEF, 64'h7766_DD00_BBAA_2211, "R6 R2 R3 R5 first");

    // R10: write aimed at the entry leaving this cycle
    @(negedge clk);
    chk("R10 leaving tag", 64'(dr_tag), 64'h021);
    chk("R10 leaving data", dr_data & lanes(dr_strb), 64'h99);
    dr_ready = 1'b1;
    wr_valid = 1'b1; wr_addr = 16'h0108; wr_len = 4'd1; wr_be = 8'h01; wr_data = 64'h42;
    @(posedge clk); #1 begin dr_ready = 1'b0; wr_valid = 1'b0; end

    drain(13'h021, 8'h38, 64'h0000_E5E4_B300_0000, "R6 R4 third");
    drain(13'h060, 8'hFF, 64'h5A07_0605_0403_0201, "R6 R7 fourth");
    drain(13'h021, 8'h01, 64'h42, "R10 new entry");
    @(negedge clk);
    chk("R7 held write left no entry", 64'(dr_valid), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule